// File: doc/BRIEF.md
# Four-Channel Memory-Mapped Timer Bank

This block groups four independent 16-bit up-counters behind a single register window. Software selects a timer with two address bits and then one of four registers inside it: a live counter, a mode word, a match value and a scratch capture register. A shared tick input advances every timer whose run bit is set. The tick is the only timebase. Clock source choice, sync gating and prescaling are handled upstream of this block.

Each timer detects two events. A compare event occurs when the incremented count equals the match value. An overflow event occurs when the count wraps from all ones to zero. An enabled event produces a single-cycle request toward an external interrupt controller, which is expected to latch it. Timer 0 keeps firing periodically. Timers 1 to 3 disarm themselves after firing, so they behave as one-shots. Only timers 0 and 1 implement the capture register.

There is no sequencing state machine. Each timer's condition is held entirely in its mode word, and the read path is one registered multiplexer.

Top module: `tmr_bank`

## Requirements
- R1: Address bits [12:11] select timer 0..3. Bits [5:4] select the register: 0 = count, 1 = mode, 2 = compare, 3 = hold. Any address with a nonzero bit in [10:6] or [3:0] is unmapped: it reads zero and writes to it change nothing. Read data appears on `rdata_o` in the cycle after `rd_en_i`.
- R2: While mode bit 0 (run) is set, each cycle with `tick_i` high adds one to the count.
- R3: While mode bit 0 is clear, the count does not change on ticks.
- R4: A ticked count whose incremented value equals the compare register sets mode bit 4 (compare flag). A ticked wrap from 0xFFFF to 0 sets mode bit 5 (overflow flag).
- R5: If mode bit 3 (zero-return) is set, a compare event loads the count with 0 instead of the incremented value.
- R6: A compare event raises the timer's request only when mode bit 1 is set. An overflow event raises it only when mode bit 2 is set. The request is high for exactly the one cycle after the tick edge, and an event whose enable is clear raises nothing.
- R7: When timers 1, 2 or 3 raise a request, mode bits 1 and 5 clear in the same edge. Timer 0 keeps mode bit 1 and fires again on every later match.
- R8: The hold register stores 16 bits on timers 0 and 1. On timers 2 and 3 it reads 0 and writes to it are ignored.
- R9: Timer n drives bit 9+n of the 16-bit `irq_lines_o`. All other bits stay 0.
- R10: A software write to count or mode takes precedence over a tick-driven update in the same cycle. A count write loads the value directly.
- R11: After reset every count, mode, compare and hold register is 0, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-advance strobe shared by all timers |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 13 | Byte offset inside the window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read |
| irq_lines_o | output | 16 | Interrupt request vector, timer n on bit 9+n |

## Verification
The assertions assume that reset is held long enough to clear every register, and that a read or write of one timer's register never overlaps a write of the same register from another source. The bus is the only writer, so this holds trivially. The one-shot disarm property assumes that no mode write lands in the edge where the timer fires. The stimulus issues accesses one at a time on falling clock edges. It writes a mode word only while the timer cannot fire in that cycle, except in the directed precedence case, which targets the count register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int MODE_W  = 6;
    localparam int MB_RUN   = 0;
    localparam int MB_CMPIE = 1;
    localparam int MB_OVFIE = 2;
    localparam int MB_ZRET  = 3;
    localparam int MB_CMPF  = 4;
    localparam int MB_OVFF  = 5;

    typedef enum logic [1:0] {
        RS_COUNT = 2'd0,
        RS_MODE  = 2'd1,
        RS_COMP  = 2'd2,
        RS_HOLD  = 2'd3
    } rsel_e;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec #(
    parameter int NCH     = 4,
    parameter int SEL_LSB = 11,
    localparam int SEL_W  = $clog2(NCH),
    localparam int ADDR_W = SEL_LSB + SEL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    output logic [SEL_W-1:0]  chan_o,
    output tmr_pkg::rsel_e    rsel_o,
    output logic              hit_o,
    output logic [NCH-1:0]    chan_wr_o
);
    assign chan_o = addr_i[ADDR_W-1:SEL_LSB];
    assign rsel_o = tmr_pkg::rsel_e'(addr_i[5:4]);
    assign hit_o  = (addr_i[SEL_LSB-1:6] == '0) && (addr_i[3:0] == 4'd0);

    for (genvar c = 0; c < NCH; c++) begin : g_wr
        assign chan_wr_o[c] = wr_en_i && hit_o && (chan_o == SEL_W'(c));
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int W       = 16,
    parameter bit HAS_HOLD = 1'b1,
    parameter bit ONESHOT  = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic                      wr_i,
    input  tmr_pkg::rsel_e            rsel_i,
    input  logic [W-1:0]              wdata_i,
    output logic [W-1:0]              count_o,
    output logic [tmr_pkg::MODE_W-1:0] mode_o,
    output logic [W-1:0]              comp_o,
    output logic [W-1:0]              hold_o,
    output logic                      irq_o
);
    import tmr_pkg::*;

    logic [W-1:0]      count_q, comp_q, nxt;
    logic [MODE_W-1:0] mode_q, mode_nx;
    logic              irq_q;
    logic              adv, cmp_hit, ovf_hit, fire;
    logic              wr_cnt, wr_mode, wr_comp;

    assign wr_cnt  = wr_i && (rsel_i == RS_COUNT);
    assign wr_mode = wr_i && (rsel_i == RS_MODE);
    assign wr_comp = wr_i && (rsel_i == RS_COMP);

    assign adv     = tick_i && mode_q[MB_RUN];
    assign nxt     = count_q + W'(1);
    assign cmp_hit = adv && (nxt == comp_q);
    assign ovf_hit = adv && (count_q == '1);
    assign fire    = (cmp_hit && mode_q[MB_CMPIE]) || (ovf_hit && mode_q[MB_OVFIE]);

    always_comb begin
        mode_nx = mode_q;
        if (cmp_hit) mode_nx[MB_CMPF] = 1'b1;
        if (ovf_hit) mode_nx[MB_OVFF] = 1'b1;
        if (ONESHOT && fire) begin
            mode_nx[MB_CMPIE] = 1'b0;
            mode_nx[MB_OVFF]  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            mode_q  <= '0;
            comp_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= fire;
            if (wr_cnt)
                count_q <= wdata_i;
            else if (adv)
                count_q <= (cmp_hit && mode_q[MB_ZRET]) ? '0 : nxt;
            if (wr_mode)
                mode_q <= wdata_i[MODE_W-1:0];
            else
                mode_q <= mode_nx;
            if (wr_comp)
                comp_q <= wdata_i;
        end
    end

    if (HAS_HOLD) begin : g_hold
        logic [W-1:0] hold_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q <= '0;
            else if (wr_i && (rsel_i == RS_HOLD))
                hold_q <= wdata_i;
        end
        assign hold_o = hold_q;
    end else begin : g_nohold
        assign hold_o = '0;
    end

    assign count_o = count_q;
    assign mode_o  = mode_q;
    assign comp_o  = comp_q;
    assign irq_o   = irq_q;

    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[MB_RUN] && !wr_cnt) |=> $stable(count_q));

    a_r2_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_q[MB_RUN] && !mode_q[MB_ZRET] && !wr_cnt)
        |=> (count_q == $past(count_q) + W'(1)));

    a_r5_zero_return: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_q[MB_RUN] && mode_q[MB_ZRET] && !wr_cnt
         && (count_q + W'(1) == comp_q)) |=> (count_q == '0));

    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(mode_q[MB_CMPIE]) || $past(mode_q[MB_OVFIE])));

    if (ONESHOT) begin : g_a_oneshot
        a_r7_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_q && !$past(wr_mode)) |-> (!mode_q[MB_CMPIE] && !mode_q[MB_OVFF]));
    end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
    parameter int NCH        = 4,
    parameter int W          = 16,
    parameter int HOLD_CHANS = 2,
    localparam int SEL_W     = $clog2(NCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en_i,
    input  logic                          hit_i,
    input  logic [SEL_W-1:0]              chan_i,
    input  tmr_pkg::rsel_e                rsel_i,
    input  logic [NCH-1:0][W-1:0]         count_i,
    input  logic [NCH-1:0][tmr_pkg::MODE_W-1:0] mode_i,
    input  logic [NCH-1:0][W-1:0]         comp_i,
    input  logic [NCH-1:0][W-1:0]         hold_i,
    output logic [W-1:0]                  rdata_o
);
    import tmr_pkg::*;

    logic [W-1:0] sel_val, rdata_q;

    always_comb begin
        sel_val = '0;
        if (hit_i) begin
            unique case (rsel_i)
                RS_COUNT: sel_val = count_i[chan_i];
                RS_MODE:  sel_val = W'(mode_i[chan_i]);
                RS_COMP:  sel_val = comp_i[chan_i];
                RS_HOLD:  sel_val = hold_i[chan_i];
                default:  sel_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en_i)
            rdata_q <= sel_val;
    end

    assign rdata_o = rdata_q;

    a_r8_absent_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && hit_i && rsel_i == RS_HOLD && int'(chan_i) >= HOLD_CHANS)
        |=> (rdata_o == '0));

    a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit_i) |=> (rdata_o == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int NCH        = 4,
    parameter int W          = 16,
    parameter int SEL_LSB    = 11,
    parameter int HOLD_CHANS = 2,
    parameter int IRQ_BASE   = 9,
    parameter int NUM_LINES  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tick_i,
    input  logic                             wr_en_i,
    input  logic                             rd_en_i,
    input  logic [SEL_LSB+$clog2(NCH)-1:0]   addr_i,
    input  logic [W-1:0]                     wdata_i,
    output logic [W-1:0]                     rdata_o,
    output logic [NUM_LINES-1:0]             irq_lines_o
);
    localparam int SEL_W = $clog2(NCH);

    logic [SEL_W-1:0]                    chan;
    tmr_pkg::rsel_e                      rsel;
    logic                                hit;
    logic [NCH-1:0]                      chan_wr;
    logic [NCH-1:0][W-1:0]               counts, comps, holds;
    logic [NCH-1:0][tmr_pkg::MODE_W-1:0] modes;
    logic [NCH-1:0]                      irqs;

    tmr_regdec #(.NCH(NCH), .SEL_LSB(SEL_LSB)) u_dec (
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .chan_o    (chan),
        .rsel_o    (rsel),
        .hit_o     (hit),
        .chan_wr_o (chan_wr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tmr_chan #(
            .W        (W),
            .HAS_HOLD (c < HOLD_CHANS),
            .ONESHOT  (c > 0)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .wr_i    (chan_wr[c]),
            .rsel_i  (rsel),
            .wdata_i (wdata_i),
            .count_o (counts[c]),
            .mode_o  (modes[c]),
            .comp_o  (comps[c]),
            .hold_o  (holds[c]),
            .irq_o   (irqs[c])
        );
    end

    tmr_rdmux #(.NCH(NCH), .W(W), .HOLD_CHANS(HOLD_CHANS)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (rd_en_i),
        .hit_i   (hit),
        .chan_i  (chan),
        .rsel_i  (rsel),
        .count_i (counts),
        .mode_i  (modes),
        .comp_i  (comps),
        .hold_i  (holds),
        .rdata_o (rdata_o)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        if (l >= IRQ_BASE && l < IRQ_BASE + NCH) begin : g_tmr
            assign irq_lines_o[l] = irqs[l - IRQ_BASE];
        end else begin : g_zero
            assign irq_lines_o[l] = 1'b0;
        end
    end
endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [12:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic [15:0] irq_lines_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tmr_bank u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_lines_o(irq_lines_o)
    );

    // {op, req, addr, data}; op 0 write, 1 read-check, 2 tick count
    localparam int NV = 30;
    localparam logic [34:0] VEC [0:NV-1] = '{
        {2'd0, 4'd10, 13'h0020, 16'd5},
        {2'd0, 4'd10, 13'h0000, 16'd0},
        {2'd0, 4'd10, 13'h0010, 16'h000B},
        {2'd2, 4'd2,  13'h0000, 16'd3},
        {2'd1, 4'd2,  13'h0000, 16'd3},     // R2 three ticks
        {2'd2, 4'd5,  13'h0000, 16'd2},
        {2'd1, 4'd5,  13'h0000, 16'd0},     // R5 zero-return at match
        {2'd1, 4'd7,  13'h0010, 16'h001B},  // R7 timer 0 keeps enable, R4 flag
        {2'd0, 4'd10, 13'h0010, 16'h0000},
        {2'd0, 4'd10, 13'h0820, 16'd2},
        {2'd0, 4'd10, 13'h0810, 16'h0003},
        {2'd2, 4'd7,  13'h0000, 16'd2},
        {2'd1, 4'd7,  13'h0810, 16'h0011},  // R7 timer 1 disarmed
        {2'd1, 4'd4,  13'h0800, 16'd2},     // R4 no zero-return keeps match value
        {2'd2, 4'd2,  13'h0000, 16'd3},
        {2'd1, 4'd2,  13'h0800, 16'd5},     // R2 keeps counting
        {2'd0, 4'd8,  13'h1030, 16'hABCD},
        {2'd1, 4'd8,  13'h1030, 16'h0000},  // R8 timer 2 no hold
        {2'd0, 4'd8,  13'h0030, 16'h1234},
        {2'd1, 4'd8,  13'h0030, 16'h1234},  // R8 timer 0 hold
        {2'd0, 4'd8,  13'h0830, 16'h00FF},
        {2'd1, 4'd8,  13'h0830, 16'h00FF},  // R8 timer 1 hold
        {2'd0, 4'd3,  13'h1000, 16'd7},
        {2'd2, 4'd3,  13'h0000, 16'd4},
        {2'd1, 4'd3,  13'h1000, 16'd7},     // R3 stopped timer
        {2'd1, 4'd1,  13'h0040, 16'd0},     // R1 unmapped read
        {2'd0, 4'd1,  13'h1820, 16'h0099},
        {2'd1, 4'd1,  13'h1820, 16'h0099},  // R1 timer 3 select
        {2'd0, 4'd1,  13'h0028, 16'h7777},
        {2'd1, 4'd1,  13'h0020, 16'd5}      // R1 unmapped write ignored
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [15:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int req, input logic [12:0] a, input logic [15:0] exp);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        chk(req, rdata_o, exp);
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic tick_irq(input int req, input logic [15:0] exp);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk(req, irq_lines_o, exp);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(11, irq_lines_o, 16'h0000);
        rd(11, 13'h0000, 16'h0000);
        rd(11, 13'h0010, 16'h0000);
        rd(11, 13'h0830, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [12:0] a;
            logic [15:0] d;
            {op, rq, a, d} = VEC[i];
            case (op)
                2'd0: wr(a, d);
                2'd1: rd(int'(rq), a, d);
                default: ticks(int'(d));
            endcase
        end

        // R9 R4 overflow on timer 3 drives line 12
        wr(13'h1800, 16'hFFFE);
        wr(13'h1810, 16'h0005);
        tick_irq(4, 16'h0000);
        tick_irq(9, 16'h1000);
        @(negedge clk);
        chk(6, irq_lines_o, 16'h0000);        // R6 single-cycle pulse
        rd(7, 13'h1810, 16'h0005);            // R7 overflow flag cleared by one-shot
        rd(4, 13'h1800, 16'h0000);            // R4 wrapped to zero

        // R6 compare without enable raises nothing
        wr(13'h1000, 16'd0);
        wr(13'h1020, 16'd2);
        wr(13'h1010, 16'h0001);
        tick_irq(6, 16'h0000);
        tick_irq(6, 16'h0000);
        rd(6, 13'h1010, 16'h0011);

        // R7 R9 timer 0 periodic on line 9
        wr(13'h0000, 16'd0);
        wr(13'h0020, 16'd2);
        wr(13'h0010, 16'h000B);
        tick_irq(7, 16'h0000);
        tick_irq(9, 16'h0200);
        tick_irq(7, 16'h0000);
        tick_irq(7, 16'h0200);

        // R10 count write wins over a tick in the same cycle
        tick_i = 1'b1;
        wr(13'h0000, 16'h0100);
        tick_i = 1'b0;
        rd(10, 13'h0000, 16'h0100);

        summary();
    end
endmodule